// File: doc/BRIEF.md
# In-Order Retirement Tracker

This block keeps in-flight instructions in program order so they can leave the pipeline in that same order. When dispatch logic offers an instruction, the block reserves capacity equal to the instruction's micro-op count and hands back a token. The token is the index of the slot the instruction now occupies in a circular slot array. Execution units later report completion by token. Each cycle the retire logic walks forward from the oldest occupied slot and consumes every consecutive completed instruction, up to a programmable per-cycle limit. The tags of the retired instructions are presented on parallel lanes in program order.

Capacity is counted in micro-ops and exposed as a free-entry count, so upstream logic can stall. The slot array holds twice as many slots as the logical capacity. An instruction with no micro-ops still takes one slot but no capacity. A separate slot budget stops a long run of such instructions from overrunning the array. The block can also look one instruction ahead of the oldest one, using the oldest slot's stride.

Top module: `rob_retire_ctrl`

## Requirements
- R1: After reset the free-entry count equals CAP, the head and dispatch tokens are 0, no lane retires and the completion error flag is low.
- R2: A dispatch returns the current write index as its token. The write index then advances by max(1, clamped micro-op count), wrapping modulo 2*CAP.
- R3: The free-entry count falls by the clamped micro-op count of each accepted dispatch and rises by the stored count of each retired instruction. A zero-micro-op instruction leaves the count unchanged.
- R4: disp_ready is high exactly when the free-entry count is at least the clamped micro-op count and the free-slot budget is at least max(1, clamped count). A dispatch offered while disp_ready is low changes no state.
- R5: A micro-op count above CAP is clamped to CAP, so such an instruction can be accepted into an empty buffer.
- R6: A completion on a dispatched, not-yet-executed slot marks it executed. A completion on an empty slot, an already executed slot or an out-of-range token changes nothing, and it raises cmpl_err for exactly the following cycle.
- R7: Retirement proceeds only in token order. It stops at the first slot that is empty or not yet executed, so a completed younger instruction waits behind an older one.
- R8: The number retired per cycle is at most ret_limit. A ret_limit of 0, or any value above LANES, allows LANES retirements.
- R9: Retired tags appear on ret_tag lanes 0 upward (lane k in bits k*TAG_W upward) in program order. ret_valid is a thermometer code from bit 0, ret_count is its population, and the retired slots become empty at the next clock edge.
- R10: While the head slot is occupied, next_token equals head_token plus max(1, head micro-op count), modulo 2*CAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_uops | input | UOP_W | Micro-op count of the offered instruction |
| disp_tag | input | TAG_W | Tag of the offered instruction |
| disp_ready | output | 1 | Dispatch will be accepted this cycle |
| disp_token | output | IDX_W | Token given to the instruction dispatched this cycle |
| cmpl_valid | input | 1 | Completion report |
| cmpl_token | input | IDX_W | Token of the completed instruction |
| cmpl_err | output | 1 | Previous cycle's completion was illegal |
| ret_limit | input | LIM_W | Per-cycle retirement cap, 0 means LANES |
| ret_valid | output | LANES | Lanes retiring this cycle |
| ret_count | output | LIM_W | Number of instructions retiring this cycle |
| ret_tag | output | LANES*TAG_W | Tags of retiring instructions, lane 0 oldest |
| head_token | output | IDX_W | Token of the oldest slot |
| next_token | output | IDX_W | Token following the oldest one |
| free_entries | output | CNT_W | Free micro-op capacity |

## Verification
The bench builds the block with CAP=4, giving an array of 8 slots, with three retire lanes and 4-bit micro-op counts. The small array makes write and read index wrap-around, a full buffer and an exhausted slot budget from zero-micro-op runs occur within a few dozen cycles. The 4-bit count can present values up to 15, which exercises clamping. The 2-bit limit input covers every limit setting: zero, values below the lane count, and a value equal to it.

// File: rtl/rob_pkg.sv
package rob_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Occupancy state of one slot of the circular array.
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_BUSY  = 2'd1,
        SLOT_DONE  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/rob_idx_step.sv
// Advances a slot index by max(1, count), wrapping at the array size.
module rob_idx_step #(
    parameter int CAP = 8,
    localparam int SLOTS = 2 * CAP,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(CAP + 1)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] cnt,
    output logic [IDX_W-1:0] nxt
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [IDX_W:0] sum;
    logic [CNT_W-1:0] stride;

    always_comb begin
        stride = (cnt == '0) ? CNT_W'(1) : cnt;
        sum    = {1'b0, idx} + (IDX_W + 1)'(stride);
        if (sum >= (IDX_W + 1)'(SLOTS)) begin
            sum = sum - (IDX_W + 1)'(SLOTS);
        end
        nxt = sum[IDX_W-1:0];
    end
endmodule

// File: rtl/rob_disp_gate.sv
// Clamps the offered micro-op count and decides whether dispatch fits.
module rob_disp_gate #(
    parameter int CAP   = 8,
    parameter int UOP_W = 4,
    localparam int SLOTS  = 2 * CAP,
    localparam int CNT_W  = $clog2(CAP + 1),
    localparam int SCNT_W = $clog2(SLOTS + 1),
    localparam int CW     = (UOP_W > CNT_W) ? UOP_W : CNT_W
) (
    input  logic [UOP_W-1:0]  uops_raw,
    input  logic [CNT_W-1:0]  free_cnt,
    input  logic [SCNT_W-1:0] free_slots,
    output logic [CNT_W-1:0]  cnt_c,
    output logic [CNT_W-1:0]  stride,
    output logic              ready
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CW-1:0] raw_x;

    always_comb begin
        raw_x  = CW'(uops_raw);
        cnt_c  = (raw_x > CW'(CAP)) ? CNT_W'(CAP) : CNT_W'(raw_x);
        stride = (cnt_c == '0) ? CNT_W'(1) : cnt_c;
        ready  = (free_cnt >= cnt_c) && (free_slots >= SCNT_W'(stride));
    end
endmodule

// File: rtl/rob_retire_pick.sv
// Chains up to LANES retirements along consecutive tokens from the head.
module rob_retire_pick
    import rob_pkg::*;
#(
    parameter int CAP   = 8,
    parameter int LANES = 4,
    localparam int SLOTS  = 2 * CAP,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(CAP + 1),
    localparam int SCNT_W = $clog2(SLOTS + 1),
    localparam int LIM_W  = $clog2(LANES + 1)
) (
    input  slot_state_e [SLOTS-1:0]            st,
    input  logic [SLOTS-1:0][CNT_W-1:0]        cnt,
    input  logic [IDX_W-1:0]                   rd,
    input  logic [LIM_W-1:0]                   limit,
    output logic [LANES-1:0]                   lane_ok,
    output logic [LANES-1:0][IDX_W-1:0]        lane_idx,
    output logic [LIM_W-1:0]                   count,
    output logic [IDX_W-1:0]                   rd_next,
    output logic [SCNT_W-1:0]                  sum_cnt,
    output logic [SCNT_W-1:0]                  sum_stride
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [LIM_W-1:0]          lim_eff;
    logic [LANES:0][IDX_W-1:0] walk;
    logic [LANES:0]            chain;

    always_comb begin
        if ((limit == '0) || (limit > LIM_W'(LANES))) begin
            lim_eff = LIM_W'(LANES);
        end else begin
            lim_eff = limit;
        end
    end

    assign walk[0]  = rd;
    assign chain[0] = 1'b1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic done_k;
        assign done_k      = (st[walk[k]] == SLOT_DONE);
        assign lane_ok[k]  = chain[k] && done_k && (LIM_W'(k) < lim_eff);
        assign chain[k+1]  = lane_ok[k];
        assign lane_idx[k] = walk[k];

        rob_idx_step #(.CAP(CAP)) u_step (
            .idx (walk[k]),
            .cnt (cnt[walk[k]]),
            .nxt (walk[k+1])
        );
    end

    always_comb begin
        count      = '0;
        rd_next    = rd;
        sum_cnt    = '0;
        sum_stride = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_ok[k]) begin
                count      = count + LIM_W'(1);
                rd_next    = walk[k+1];
                sum_cnt    = sum_cnt + SCNT_W'(cnt[walk[k]]);
                sum_stride = sum_stride +
                             ((cnt[walk[k]] == '0) ? SCNT_W'(1) : SCNT_W'(cnt[walk[k]]));
            end
        end
    end
endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl
    import rob_pkg::*;
#(
    parameter int CAP   = 8,
    parameter int LANES = 4,
    parameter int TAG_W = 8,
    parameter int UOP_W = 4,
    localparam int SLOTS  = 2 * CAP,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(CAP + 1),
    localparam int SCNT_W = $clog2(SLOTS + 1),
    localparam int LIM_W  = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_valid,
    input  logic [UOP_W-1:0]       disp_uops,
    input  logic [TAG_W-1:0]       disp_tag,
    output logic                   disp_ready,
    output logic [IDX_W-1:0]       disp_token,
    input  logic                   cmpl_valid,
    input  logic [IDX_W-1:0]       cmpl_token,
    output logic                   cmpl_err,
    input  logic [LIM_W-1:0]       ret_limit,
    output logic [LANES-1:0]       ret_valid,
    output logic [LIM_W-1:0]       ret_count,
    output logic [LANES*TAG_W-1:0] ret_tag,
    output logic [IDX_W-1:0]       head_token,
    output logic [IDX_W-1:0]       next_token,
    output logic [CNT_W-1:0]       free_entries
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        slot_state_e [SLOTS-1:0]     st;
        logic [SLOTS-1:0][CNT_W-1:0] cnt;
        logic [SLOTS-1:0][TAG_W-1:0] tag;
        logic [IDX_W-1:0]            wr;
        logic [IDX_W-1:0]            rd;
        logic [CNT_W-1:0]            free;
        logic [SCNT_W-1:0]           sfree;
        logic                        err;
    } state_t;

    state_t d, q;

    // Dispatch side
    logic [CNT_W-1:0] cnt_c;
    logic [CNT_W-1:0] stride_c;
    logic             fire;
    logic [IDX_W-1:0] wr_adv;

    rob_disp_gate #(.CAP(CAP), .UOP_W(UOP_W)) u_gate (
        .uops_raw   (disp_uops),
        .free_cnt   (q.free),
        .free_slots (q.sfree),
        .cnt_c      (cnt_c),
        .stride     (stride_c),
        .ready      (disp_ready)
    );

    rob_idx_step #(.CAP(CAP)) u_wstep (
        .idx (q.wr),
        .cnt (cnt_c),
        .nxt (wr_adv)
    );

    assign fire = disp_valid && disp_ready;

    // Retire side
    logic [LANES-1:0]            lane_ok;
    logic [LANES-1:0][IDX_W-1:0] lane_idx;
    logic [IDX_W-1:0]            rd_next;
    logic [SCNT_W-1:0]           sum_cnt;
    logic [SCNT_W-1:0]           sum_stride;

    rob_retire_pick #(.CAP(CAP), .LANES(LANES)) u_pick (
        .st         (q.st),
        .cnt        (q.cnt),
        .rd         (q.rd),
        .limit      (ret_limit),
        .lane_ok    (lane_ok),
        .lane_idx   (lane_idx),
        .count      (ret_count),
        .rd_next    (rd_next),
        .sum_cnt    (sum_cnt),
        .sum_stride (sum_stride)
    );

    // Look-ahead to the token after the head
    rob_idx_step #(.CAP(CAP)) u_peek (
        .idx (q.rd),
        .cnt (q.cnt[q.rd]),
        .nxt (next_token)
    );

    // Completion side
    logic tok_in_range;
    logic cmpl_hit;

    always_comb begin
        tok_in_range = ({1'b0, cmpl_token} < (IDX_W + 1)'(SLOTS));
        cmpl_hit     = cmpl_valid && tok_in_range && (q.st[cmpl_token] == SLOT_BUSY);
    end

    // Next-state
    always_comb begin
        d = q;

        for (int k = 0; k < LANES; k++) begin
            if (lane_ok[k]) begin
                d.st[lane_idx[k]]  = SLOT_EMPTY;
                d.cnt[lane_idx[k]] = '0;
                d.tag[lane_idx[k]] = '0;
            end
        end
        d.rd = rd_next;

        if (fire) begin
            d.st[q.wr]  = SLOT_BUSY;
            d.cnt[q.wr] = cnt_c;
            d.tag[q.wr] = disp_tag;
            d.wr        = wr_adv;
        end

        if (cmpl_hit) begin
            d.st[cmpl_token] = SLOT_DONE;
        end
        d.err = cmpl_valid && !cmpl_hit;

        d.free  = CNT_W'(SCNT_W'(q.free) - (fire ? SCNT_W'(cnt_c) : '0) + sum_cnt);
        d.sfree = q.sfree - (fire ? SCNT_W'(stride_c) : '0) + sum_stride;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.free  <= CNT_W'(CAP);
            q.sfree <= SCNT_W'(SLOTS);
        end else begin
            q <= d;
        end
    end

    // Outputs
    assign disp_token   = q.wr;
    assign cmpl_err     = q.err;
    assign head_token   = q.rd;
    assign free_entries = q.free;
    assign ret_valid    = lane_ok;

    for (genvar k = 0; k < LANES; k++) begin : g_tag_out
        assign ret_tag[k*TAG_W +: TAG_W] = lane_ok[k] ? q.tag[lane_idx[k]] : '0;
    end

    // Assertions
    a_r3_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        free_entries <= CNT_W'(CAP));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(disp_valid && disp_ready) && (ret_count == '0)) |=> $stable(free_entries));

    a_r2_zero_uop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready && (disp_uops == '0)) |=>
        (disp_token == (($past(disp_token) == IDX_W'(SLOTS - 1)) ? '0
                                                                  : $past(disp_token) + 1'b1)));

    a_r6_double_done: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && tok_in_range && (q.st[cmpl_token] == SLOT_DONE)) |=> cmpl_err);

    a_r8_limit_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_limit != '0) |-> (ret_count <= ret_limit));

    a_r9_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret_valid & (ret_valid + LANES'(1))) == '0) &&
        ($countones(ret_valid) == int'(ret_count)));
endmodule

// File: tb/sim_rob_retire_ctrl.sv
module sim_rob_retire_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CAP    = 4;
    localparam int LANES  = 3;
    localparam int TAG_W  = 8;
    localparam int UOP_W  = 4;
    localparam int SLOTS  = 2 * CAP;
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int CNT_W  = $clog2(CAP + 1);
    localparam int LIM_W  = $clog2(LANES + 1);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   disp_valid = 1'b0;
    logic [UOP_W-1:0]       disp_uops = '0;
    logic [TAG_W-1:0]       disp_tag = '0;
    logic                   disp_ready;
    logic [IDX_W-1:0]       disp_token;
    logic                   cmpl_valid = 1'b0;
    logic [IDX_W-1:0]       cmpl_token = '0;
    logic                   cmpl_err;
    logic [LIM_W-1:0]       ret_limit = '0;
    logic [LANES-1:0]       ret_valid;
    logic [LIM_W-1:0]       ret_count;
    logic [LANES*TAG_W-1:0] ret_tag;
    logic [IDX_W-1:0]       head_token;
    logic [IDX_W-1:0]       next_token;
    logic [CNT_W-1:0]       free_entries;

    always #4 clk = ~clk;

    rob_retire_ctrl #(.CAP(CAP), .LANES(LANES), .TAG_W(TAG_W), .UOP_W(UOP_W)) u0 (
        .clk, .rst_n, .disp_valid, .disp_uops, .disp_tag, .disp_ready, .disp_token,
        .cmpl_valid, .cmpl_token, .cmpl_err, .ret_limit, .ret_valid, .ret_count,
        .ret_tag, .head_token, .next_token, .free_entries
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model: 0 empty, 1 dispatched, 2 executed
    int m_st [SLOTS];
    int m_cnt[SLOTS];
    int m_tag[SLOTS];
    int m_wr = 0, m_rd = 0, m_free = CAP, m_sfree = SLOTS;
    bit m_err = 0;
    bit [31:0] seed = 32'h1234_5678;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic bit [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic step(input bit dv, input int du, input int dt,
                        input bit cv, input int ct, input int lim);
        int uc, sd, le, n, idx, su, ss, act_tag;
        bit rdy, bad;
        int ridx[LANES];
        disp_valid = dv;
        disp_uops  = UOP_W'(du);
        disp_tag   = TAG_W'(dt);
        cmpl_valid = cv;
        cmpl_token = IDX_W'(ct);
        ret_limit  = LIM_W'(lim);
        #1;
        uc  = (du > CAP) ? CAP : du;
        sd  = (uc == 0) ? 1 : uc;
        rdy = (m_free >= uc) && (m_sfree >= sd);
        chk(disp_ready == rdy, "R4 R5 disp_ready", int'(disp_ready), int'(rdy));
        chk(int'(disp_token) == m_wr, "R2 disp_token", int'(disp_token), m_wr);
        chk(int'(free_entries) == m_free, "R3 free_entries", int'(free_entries), m_free);
        chk(cmpl_err == m_err, "R6 cmpl_err", int'(cmpl_err), int'(m_err));
        chk(int'(head_token) == m_rd, "R7 head_token", int'(head_token), m_rd);
        if (m_st[m_rd] != 0) begin
            int exp_nt;
            exp_nt = (m_rd + ((m_cnt[m_rd] == 0) ? 1 : m_cnt[m_rd])) % SLOTS;
            chk(int'(next_token) == exp_nt, "R10 next_token", int'(next_token), exp_nt);
        end
        le = (lim == 0 || lim > LANES) ? LANES : lim;
        n = 0; idx = m_rd; su = 0; ss = 0;
        while (n < le && m_st[idx] == 2) begin
            act_tag = int'(ret_tag[n*TAG_W +: TAG_W]);
            chk(act_tag == m_tag[idx], "R9 ret_tag lane", act_tag, m_tag[idx]);
            ridx[n] = idx;
            su += m_cnt[idx];
            ss += (m_cnt[idx] == 0) ? 1 : m_cnt[idx];
            idx = (idx + ((m_cnt[idx] == 0) ? 1 : m_cnt[idx])) % SLOTS;
            n++;
        end
        chk(int'(ret_count) == n, "R7 R8 ret_count", int'(ret_count), n);
        chk(int'(ret_valid) == ((1 << n) - 1), "R9 ret_valid", int'(ret_valid), (1 << n) - 1);
        // model update
        bad = cv && (ct >= SLOTS || m_st[ct] != 1);
        for (int k = 0; k < n; k++) begin
            m_st[ridx[k]] = 0; m_cnt[ridx[k]] = 0; m_tag[ridx[k]] = 0;
        end
        m_rd = idx;
        m_free += su;
        m_sfree += ss;
        if (dv && rdy) begin
            m_st[m_wr] = 1; m_cnt[m_wr] = uc; m_tag[m_wr] = dt & 8'hFF;
            m_wr = (m_wr + sd) % SLOTS;
            m_free -= uc;
            m_sfree -= sd;
        end
        if (cv && !bad) m_st[ct] = 2;
        m_err = bad;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int lim);
        step(0, 0, 0, 0, 0, lim);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < SLOTS; i++) begin m_st[i] = 0; m_cnt[i] = 0; m_tag[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        chk(int'(free_entries) == CAP, "R1 reset free_entries", int'(free_entries), CAP);
        chk(head_token == '0, "R1 reset head_token", int'(head_token), 0);
        chk(disp_token == '0, "R1 reset disp_token", int'(disp_token), 0);
        chk(ret_count == '0, "R1 reset ret_count", int'(ret_count), 0);
        chk(cmpl_err == 1'b0, "R1 reset cmpl_err", int'(cmpl_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle(0);

        // R2 R3: dispatch 2 uops then a zero-uop instruction
        step(1, 2, 8'h11, 0, 0, 0);
        step(1, 0, 8'h22, 0, 0, 0);
        // R4 R5: oversized count clamps to 4 but only 2 free: rejected
        step(1, 9, 8'h33, 0, 0, 0);
        // R7: younger completes first, nothing retires
        step(0, 0, 0, 1, 2, 0);
        idle(0);
        // R6: second completion of token 2 is an error
        step(0, 0, 0, 1, 2, 0);
        // R6: completion of empty slot 5
        step(0, 0, 0, 1, 5, 0);
        // complete head, both retire together next cycle
        step(0, 0, 0, 1, 0, 0);
        idle(0);
        idle(0);
        // R5: oversized into empty buffer
        step(1, 12, 8'h44, 0, 0, 0);
        step(1, 0, 8'h45, 0, 0, 0);
        step(0, 0, 0, 1, 3, 0);
        idle(0);
        // R8: several zero-uop instructions retired under each limit
        for (int i = 0; i < 6; i++) step(1, 0, 8'h50 + i, 0, 0, 0);
        for (int i = 0; i < SLOTS; i++) step(0, 0, 0, 1, i, 1);
        idle(1); idle(1);
        idle(2); idle(2);
        idle(3); idle(0); idle(0);
        // R4: slot budget exhaustion with zero-uop runs
        for (int i = 0; i < 10; i++) step(1, 0, 8'h60 + i, 0, 0, 0);
        for (int i = 0; i < SLOTS; i++) step(0, 0, 0, 1, i, 0);
        idle(0); idle(0); idle(0); idle(0);

        // Pseudo-random traffic
        for (int i = 0; i < 4000; i++) begin
            bit [31:0] r, r2;
            int du, ct, st0;
            bit cv;
            r  = rnd();
            r2 = rnd();
            du = (r[7:4] == 4'hF) ? 15 : int'(r[6:4]) % 6;
            cv = (r[11:8] < 4'd11);
            st0 = int'(r2[15:0]) % SLOTS;
            ct = st0;
            if (r[12]) begin
                for (int j = 0; j < SLOTS; j++) begin
                    if (m_st[(st0 + j) % SLOTS] == 1) begin
                        ct = (st0 + j) % SLOTS;
                        break;
                    end
                end
            end
            step(r[0] | r[1], du, int'(r2[23:16]), cv, ct, int'(r2[25:24]));
        end
        for (int i = 0; i < 6; i++) idle(0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule